// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block translates a 48-bit virtual address into a physical address by reading translation descriptors from memory one level at a time. A request carries the virtual address, the kind of access (data read, data write or instruction fetch) and the privilege of the requester. The walker picks the upper or lower table base from the top sixteen address bits. It then issues one descriptor read per level on a simple request/response port. The walk stops at a page descriptor on the last level, at a block descriptor on the second or third level, or at the first fault.

When the walk ends, the block pulses `done_o` for one cycle. On success it returns the physical address, the memory-attribute index and the level that ended the walk. On failure it returns a fault type and the level at which the walk stopped. A faulting walk produces no physical address. The granule is 4 KB, and each level consumes nine bits of the virtual address. Levels are numbered 0 (top) to 3 (last).

Top module: `pt_walker`

## Requirements
- R1: After reset, `req_ready_o` is 1, `mem_req_o` is 0 and `done_o` is 0.
- R2: A VA whose bits [63:48] are all ones walks from `base_hi_i`, and one whose bits [63:48] are all zero walks from `base_lo_i`. Any other VA ends with fault type 0 (address size) at level 0 and issues no memory read.
- R3: The descriptor address at level L is the current table base plus 8 times the 9-bit index. The index is VA[47:39] at level 0, [38:30] at level 1, [29:21] at level 2 and [20:12] at level 3. `mem_req_o` and `mem_addr_o` hold steady until a cycle with `mem_rsp_valid_i` high, which consumes the response.
- R4: A descriptor with bits [1:0]=11 at levels 0 to 2 is a table pointer, and the next table base is descriptor bits [47:12] followed by twelve zeros.
- R5: A descriptor with bits [1:0]=11 at level 3 is a page, and the physical address is {desc[47:12], VA[11:0]}.
- R6: A descriptor with bits [1:0]=01 at level 1 is a 1 GB block giving {desc[47:30], VA[29:0]}. At level 2 it is a 2 MB block giving {desc[47:21], VA[20:0]}. At levels 0 and 3 the value 01 is a translation fault. A successful walk reports the level it ended at.
- R7: A descriptor with bit 0 clear ends the walk with fault type 1 (translation) at the level where it was read. A faulting walk reports `pa_o` and `attr_idx_o` as 0.
- R8: A final descriptor with bit 10 (access flag) clear gives fault type 2. This fault takes precedence over a permission fault.
- R9: Access types are encoded 0 for read, 1 for write and 2 for fetch, and `req_priv_i`=1 means privileged. A user access to a final descriptor with bit 6 clear, or a write where bit 7 is set, gives fault type 3 (permission). Privileged data access ignores bit 6.
- R10: A user fetch faults with type 3 when bit 54 is set. A privileged fetch faults with type 3 when bit 53 is set, or when bits [7:6]=01 regardless of bit 53.
- R11: `attr_idx_o` returns bits [4:2] of the final descriptor. `done_o` is a one-cycle pulse in the cycle after the final response is consumed, or after acceptance when the address-size fault applies. `req_ready_o` is low from acceptance through the `done_o` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Translation request strobe |
| req_ready_o | output | 1 | Walker idle, request accepted when valid |
| req_va_i | input | 64 | Virtual address |
| req_acc_i | input | 2 | Access type: 0 read, 1 write, 2 fetch |
| req_priv_i | input | 1 | 1 privileged, 0 user |
| base_lo_i | input | 48 | Top-level table base for the lower half |
| base_hi_i | input | 48 | Top-level table base for the upper half |
| mem_req_o | output | 1 | Descriptor read request |
| mem_addr_o | output | 48 | Descriptor physical address |
| mem_rsp_valid_i | input | 1 | Descriptor data valid |
| mem_rsp_data_i | input | 64 | Descriptor data |
| done_o | output | 1 | Result valid pulse |
| pa_o | output | 48 | Physical address |
| attr_idx_o | output | 3 | Memory-attribute index |
| fault_o | output | 1 | Walk ended in a fault |
| fault_type_o | output | 2 | 0 address size, 1 translation, 2 access flag, 3 permission |
| fault_level_o | output | 2 | Level at which the walk ended |

## Verification
The hardest cases to reach are faults that need a specific descriptor at a specific depth. Examples are a block encoding at the top or last level, an invalid entry in the middle of a chain, and a final descriptor that breaks the access-flag and privilege rules at the same time. The bench builds a sparse memory of descriptor chains with a fresh table frame per level for each case. This lets any level end the walk with any chosen descriptor. A behavioural reference walks the same memory to predict every read address and the result. Responses come back after 0 to 3 cycles of delay, so the held request is also exercised.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int VA_W    = 48;
  localparam int PA_W    = 48;
  localparam int LVLS    = 4;
  localparam int IDX_W   = 9;
  localparam int PG_OFF  = 12;
  localparam int LVL_W   = $clog2(LVLS);
  localparam int DESC_W  = 64;

  typedef enum logic [1:0] {ACC_READ = 2'd0, ACC_WRITE = 2'd1, ACC_FETCH = 2'd2} acc_e;
  typedef enum logic [1:0] {FLT_ADDR = 2'd0, FLT_XLAT = 2'd1, FLT_AF = 2'd2, FLT_PERM = 2'd3} flt_e;
  typedef enum logic [1:0] {ST_IDLE, ST_WALK, ST_DONE} st_e;
endpackage

// File: rtl/ptw_desc_decode.sv
module ptw_desc_decode
  import ptw_pkg::*;
(
  input  logic [DESC_W-1:0] desc_i,
  input  logic [LVL_W-1:0]  lvl_i,
  input  logic [VA_W-1:0]   va_i,
  output logic              next_o,
  output logic              leaf_o,
  output logic              bad_o,
  output logic [PA_W-1:0]   next_base_o,
  output logic [PA_W-1:0]   leaf_pa_o
);
  localparam logic [LVL_W-1:0] LAST = LVL_W'(LVLS - 1);

  // offset mask per level: bits kept from the VA
  logic [PA_W-1:0] lvl_mask [LVLS];
  for (genvar g = 0; g < LVLS; g++) begin : g_mask
    localparam int SH = PG_OFF + IDX_W * (LVLS - 1 - g);
    assign lvl_mask[g] = (PA_W'(1) << SH) - PA_W'(1);
  end

  logic [PA_W-1:0] mask;
  logic            unused_bits;

  always_comb begin
    mask        = lvl_mask[lvl_i];
    next_o      = (desc_i[1:0] == 2'b11) && (lvl_i != LAST);
    leaf_o      = ((desc_i[1:0] == 2'b11) && (lvl_i == LAST)) ||
                  ((desc_i[1:0] == 2'b01) && (lvl_i != '0) && (lvl_i != LAST));
    bad_o       = !next_o && !leaf_o;
    next_base_o = {desc_i[PA_W-1:PG_OFF], {PG_OFF{1'b0}}};
    leaf_pa_o   = (desc_i[PA_W-1:0] & ~mask) | (va_i[PA_W-1:0] & mask);
  end

  assign unused_bits = ^desc_i[DESC_W-1:PA_W];
endmodule

// File: rtl/ptw_perm_check.sv
module ptw_perm_check
  import ptw_pkg::*;
(
  input  logic [DESC_W-1:0] desc_i,
  input  logic [1:0]        acc_i,
  input  logic              priv_i,
  output logic              af_flt_o,
  output logic              perm_flt_o
);
  logic ro, usr, pxn, uxn;
  logic unused_bits;

  assign ro  = desc_i[7];
  assign usr = desc_i[6];
  assign pxn = desc_i[53];
  assign uxn = desc_i[54];

  always_comb begin
    af_flt_o   = !desc_i[10];
    perm_flt_o = 1'b0;
    if (!priv_i && !usr) perm_flt_o = 1'b1;
    if (acc_i == ACC_WRITE && ro) perm_flt_o = 1'b1;
    if (acc_i == ACC_FETCH) begin
      if (!priv_i && uxn) perm_flt_o = 1'b1;
      // user-writable regions are never privileged-executable
      if (priv_i && (pxn || (usr && !ro))) perm_flt_o = 1'b1;
    end
  end

  assign unused_bits = ^{desc_i[63:55], desc_i[52:11], desc_i[9:8], desc_i[5:0]};
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [63:0]       req_va_i,
  input  logic [1:0]        req_acc_i,
  input  logic              req_priv_i,
  input  logic [PA_W-1:0]   base_lo_i,
  input  logic [PA_W-1:0]   base_hi_i,
  output logic              mem_req_o,
  output logic [PA_W-1:0]   mem_addr_o,
  input  logic              mem_rsp_valid_i,
  input  logic [DESC_W-1:0] mem_rsp_data_i,
  output logic              done_o,
  output logic [PA_W-1:0]   pa_o,
  output logic [2:0]        attr_idx_o,
  output logic              fault_o,
  output logic [1:0]        fault_type_o,
  output logic [LVL_W-1:0]  fault_level_o
);
  st_e              state_q;
  logic [LVL_W-1:0] lvl_q;
  logic [PA_W-1:0]  tbl_q;
  logic [VA_W-1:0]  va_q;
  logic [1:0]       acc_q;
  logic             priv_q;
  logic [PA_W-1:0]  pa_q;
  logic [2:0]       attr_q;
  logic             flt_q;
  logic [1:0]       ftype_q;
  logic [LVL_W-1:0] flvl_q;

  logic upper_half, lower_half;
  assign upper_half = &req_va_i[63:VA_W];
  assign lower_half = ~|req_va_i[63:VA_W];

  // descriptor index for the current level
  logic [IDX_W-1:0] idx;
  logic [VA_W-1:0]  va_sh;
  always_comb begin
    va_sh = va_q >> (PG_OFF + IDX_W * (int'(LVLS - 1) - int'(lvl_q)));
    idx   = va_sh[IDX_W-1:0];
  end

  logic            dec_next, dec_leaf, dec_bad;
  logic [PA_W-1:0] dec_base, dec_pa;
  logic            af_flt, perm_flt;

  ptw_desc_decode u_dec (
    .desc_i      (mem_rsp_data_i),
    .lvl_i       (lvl_q),
    .va_i        (va_q),
    .next_o      (dec_next),
    .leaf_o      (dec_leaf),
    .bad_o       (dec_bad),
    .next_base_o (dec_base),
    .leaf_pa_o   (dec_pa)
  );

  ptw_perm_check u_perm (
    .desc_i     (mem_rsp_data_i),
    .acc_i      (acc_q),
    .priv_i     (priv_q),
    .af_flt_o   (af_flt),
    .perm_flt_o (perm_flt)
  );

  logic unused_leaf;
  assign unused_leaf = dec_leaf;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      lvl_q   <= '0;
      tbl_q   <= '0;
      va_q    <= '0;
      acc_q   <= '0;
      priv_q  <= 1'b0;
      pa_q    <= '0;
      attr_q  <= '0;
      flt_q   <= 1'b0;
      ftype_q <= '0;
      flvl_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (req_valid_i) begin
          va_q   <= req_va_i[VA_W-1:0];
          acc_q  <= req_acc_i;
          priv_q <= req_priv_i;
          lvl_q  <= '0;
          if (upper_half || lower_half) begin
            tbl_q   <= upper_half ? base_hi_i : base_lo_i;
            state_q <= ST_WALK;
          end else begin
            pa_q    <= '0;
            attr_q  <= '0;
            flt_q   <= 1'b1;
            ftype_q <= FLT_ADDR;
            flvl_q  <= '0;
            state_q <= ST_DONE;
          end
        end
        ST_WALK: if (mem_rsp_valid_i) begin
          if (dec_next) begin
            tbl_q <= dec_base;
            lvl_q <= lvl_q + 1'b1;
          end else begin
            state_q <= ST_DONE;
            flvl_q  <= lvl_q;
            pa_q    <= '0;
            attr_q  <= '0;
            flt_q   <= 1'b1;
            if (dec_bad)       ftype_q <= FLT_XLAT;
            else if (af_flt)   ftype_q <= FLT_AF;
            else if (perm_flt) ftype_q <= FLT_PERM;
            else begin
              flt_q   <= 1'b0;
              ftype_q <= '0;
              pa_q    <= dec_pa;
              attr_q  <= mem_rsp_data_i[4:2];
            end
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o   = (state_q == ST_IDLE);
  assign mem_req_o     = (state_q == ST_WALK);
  assign mem_addr_o    = tbl_q + {{(PA_W-IDX_W-3){1'b0}}, idx, 3'b000};
  assign done_o        = (state_q == ST_DONE);
  assign pa_o          = pa_q;
  assign attr_idx_o    = attr_q;
  assign fault_o       = flt_q;
  assign fault_type_o  = ftype_q;
  assign fault_level_o = flvl_q;

  p_addr_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_rsp_valid_i |=> mem_req_o && $stable(mem_addr_o));
  p_done_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_busy_not_ready_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o || done_o) |-> !req_ready_o);
  p_fault_no_pa_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && fault_o |-> pa_o == '0 && attr_idx_o == '0);
  p_leaf_level_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !fault_o |-> fault_level_o != '0);
  p_addr_fault_no_read_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o && req_valid_i && !(upper_half || lower_half) |=> !mem_req_o && done_o);
endmodule

// File: tb/sim_pt_walker.sv
module sim_pt_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_va = '0;
  logic [1:0]  req_acc = '0;
  logic        req_priv = 1'b0;
  logic [47:0] base_lo = 48'h1000;
  logic [47:0] base_hi = 48'h2000;
  logic        mem_req;
  logic [47:0] mem_addr;
  logic        rsp_valid = 1'b0;
  logic [63:0] rsp_data = '0;
  logic        done;
  logic [47:0] pa;
  logic [2:0]  attr;
  logic        flt;
  logic [1:0]  ftype;
  logic [1:0]  flvl;

  always #4 clk = ~clk;

  pt_walker u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_va_i(req_va), .req_acc_i(req_acc), .req_priv_i(req_priv),
    .base_lo_i(base_lo), .base_hi_i(base_hi), .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_rsp_valid_i(rsp_valid), .mem_rsp_data_i(rsp_data), .done_o(done), .pa_o(pa),
    .attr_idx_o(attr), .fault_o(flt), .fault_type_o(ftype), .fault_level_o(flvl)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [63:0] mem [longint unsigned];
  longint unsigned next_frame = 64'h10_0000;

  longint unsigned exp_addr[$];
  logic        e_flt;
  logic [1:0]  e_type, e_lvl;
  logic [47:0] e_pa;
  logic [2:0]  e_attr;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: run hung, actual cycle %0d expected < 150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] rd(input longint unsigned a);
    return mem.exists(a) ? mem[a] : 64'd0;
  endfunction

  function automatic longint unsigned daddr(input longint unsigned tbl, input logic [63:0] va, input int l);
    return tbl + ((va >> (39 - 9 * l)) & 64'h1FF) * 8;
  endfunction

  function automatic logic [63:0] mk(input logic [47:0] addr, input logic [1:0] ty, input bit af,
                                     input bit ro, input bit usr, input bit pxn, input bit uxn,
                                     input logic [2:0] ai);
    logic [63:0] d;
    d = {16'd0, addr} | 64'(ty) | (64'(ai) << 2);
    d[10] = af; d[7] = ro; d[6] = usr; d[53] = pxn; d[54] = uxn;
    return d;
  endfunction

  task automatic build(input longint unsigned root, input logic [63:0] va, input int leaf_lvl,
                       input logic [63:0] leaf);
    longint unsigned tbl = root;
    for (int l = 0; l < leaf_lvl; l++) begin
      longint unsigned nf = next_frame;
      next_frame += 64'h1000;
      mem[daddr(tbl, va, l)] = nf | 64'h3;
      tbl = nf;
    end
    mem[daddr(tbl, va, leaf_lvl)] = leaf;
  endtask

  task automatic ref_walk(input logic [63:0] va, input logic [1:0] acc, input bit priv);
    longint unsigned tbl;
    logic [63:0] d;
    bit hi = &va[63:48];
    bit lo = ~|va[63:48];
    exp_addr.delete();
    e_flt = 1; e_type = 0; e_lvl = 0; e_pa = 0; e_attr = 0;
    if (!(hi || lo)) return;
    tbl = hi ? longint'(base_hi) : longint'(base_lo);
    for (int l = 0; l < 4; l++) begin
      longint unsigned a = daddr(tbl, va, l);
      exp_addr.push_back(a);
      d = rd(a);
      e_lvl = 2'(l);
      if (!d[0] || (!d[1] && (l == 0 || l == 3))) begin e_type = 1; return; end
      if (d[1] && l < 3) begin tbl = d & 64'h0000_FFFF_FFFF_F000; continue; end
      if (!d[10]) begin e_type = 2; return; end
      begin
        bit bad = 0;
        if (!priv && !d[6]) bad = 1;
        if (acc == 1 && d[7]) bad = 1;
        if (acc == 2 && !priv && d[54]) bad = 1;
        if (acc == 2 && priv && (d[53] || d[7:6] == 2'b01)) bad = 1;
        if (bad) begin e_type = 3; return; end
      end
      begin
        int sz = 12 + 9 * (3 - l);
        logic [47:0] m = (48'd1 << sz) - 48'd1;
        e_flt = 0; e_type = 0;
        e_pa = (d[47:0] & ~m) | (va[47:0] & m);
        e_attr = d[4:2];
        return;
      end
    end
  endtask

  task automatic run(input logic [63:0] va, input logic [1:0] acc, input bit priv,
                     input int dly, input string tag);
    int k = 0;
    bit fin = 0;
    ref_walk(va, acc, priv);
    @(negedge clk);
    chk(req_ready, 1, {tag, " R11 ready idle"});
    req_valid = 1; req_va = va; req_acc = acc; req_priv = priv;
    @(negedge clk);
    req_valid = 0;
    for (int i = 0; i < 80 && !fin; i++) begin
      if (done) begin
        fin = 1;
        chk(flt, e_flt, {tag, " fault flag"});
        chk(ftype, e_type, {tag, " fault type"});
        chk(flvl, e_lvl, {tag, " level"});
        chk(pa, e_pa, {tag, " pa"});
        chk(attr, e_attr, {tag, " R11 attr index"});
        chk(k, exp_addr.size(), {tag, " R3 read count"});
      end else begin
        chk(req_ready, 0, {tag, " R11 ready low while busy"});
        if (mem_req) begin
          logic [47:0] a0 = mem_addr;
          chk(a0, (k < exp_addr.size()) ? exp_addr[k] : 64'hDEAD, {tag, " R3 descriptor address"});
          for (int w = 0; w < dly; w++) begin
            @(negedge clk);
            chk({mem_req, mem_addr}, {1'b1, a0}, {tag, " R3 request held"});
          end
          rsp_valid = 1; rsp_data = rd(a0);
          @(negedge clk);
          rsp_valid = 0;
          k++;
        end else @(negedge clk);
      end
    end
    if (!fin) begin
      errors++;
      $display("FAIL %s R11: actual no done pulse expected done", tag);
    end
  endtask

  initial begin
    #2;
    chk({req_ready, mem_req, done}, 3'b100, "R1 reset state");
    repeat (3) @(negedge clk);
    chk({req_ready, mem_req, done}, 3'b100, "R1 reset held");
    rst_n = 1;

    // R5 R4: lower half 4-level page, user read
    build(64'h1000, 64'h0000_1234_5678_9ABC, 3, mk(48'h3_4567_8000, 2'b11, 1, 0, 1, 0, 0, 3'd5));
    run(64'h0000_1234_5678_9ABC, 0, 0, 0, "R5 page lo");
    // R2: upper half from high base, privileged write
    build(64'h2000, 64'hFFFF_8000_0040_1008, 3, mk(48'h9_9999_9000, 2'b11, 1, 0, 0, 0, 0, 3'd2));
    run(64'hFFFF_8000_0040_1008, 1, 1, 2, "R2 page hi");
    // R6: 1 GB block at level 1
    build(64'h1000, 64'h0000_0000_7ABC_DEF0, 1, mk(48'h0_4000_0000, 2'b01, 1, 0, 1, 0, 0, 3'd1));
    run(64'h0000_0000_7ABC_DEF0, 0, 0, 1, "R6 1G block");
    // R6: 2 MB block, stray low address bits ignored
    build(64'h1000, 64'h0000_0040_0012_3456, 2, mk(48'h0_8021_F000, 2'b01, 1, 0, 1, 0, 0, 3'd7));
    run(64'h0000_0040_0012_3456, 0, 0, 3, "R6 2M block");
    // R6: block encoding at top and last level
    build(64'h1000, 64'h0000_7000_0000_0000, 0, mk(48'h0, 2'b01, 1, 0, 1, 0, 0, 3'd0));
    run(64'h0000_7000_0000_0000, 0, 0, 0, "R6 block at level 0");
    build(64'h1000, 64'h0000_5555_0000_3000, 3, mk(48'h1_0000_0000, 2'b01, 1, 0, 1, 0, 0, 3'd0));
    run(64'h0000_5555_0000_3000, 0, 0, 1, "R6 block at level 3");
    // R7: invalid at level 2 and level 0
    build(64'h1000, 64'h0000_6000_4000_0000, 2, 64'h2);
    run(64'h0000_6000_4000_0000, 0, 1, 0, "R7 invalid level 2");
    run(64'hFFFF_FF80_0000_0000, 0, 1, 0, "R7 invalid level 0");
    // R8: access flag clear wins over permission fault
    build(64'h1000, 64'h0000_0100_0000_1000, 3, mk(48'h5_0000_0000, 2'b11, 0, 1, 0, 0, 0, 3'd4));
    run(64'h0000_0100_0000_1000, 1, 0, 0, "R8 af before perm");
    // R9
    build(64'h1000, 64'h0000_0200_0000_2000, 3, mk(48'h6_0000_0000, 2'b11, 1, 1, 1, 0, 0, 3'd3));
    run(64'h0000_0200_0000_2000, 1, 1, 0, "R9 write read-only");
    run(64'h0000_0200_0000_2000, 0, 0, 0, "R9 user read ro-user ok");
    build(64'h1000, 64'h0000_0300_0000_3000, 3, mk(48'h7_0000_0000, 2'b11, 1, 0, 0, 0, 0, 3'd6));
    run(64'h0000_0300_0000_3000, 0, 0, 0, "R9 user on kernel page");
    run(64'h0000_0300_0000_3000, 1, 1, 0, "R9 priv write kernel ok");
    // R10
    build(64'h1000, 64'h0000_0400_0000_4000, 3, mk(48'h8_0000_0000, 2'b11, 1, 1, 1, 1, 1, 3'd1));
    run(64'h0000_0400_0000_4000, 2, 0, 0, "R10 user fetch uxn");
    run(64'h0000_0400_0000_4000, 2, 1, 0, "R10 priv fetch pxn");
    build(64'h1000, 64'h0000_0500_0000_5000, 3, mk(48'h8_1000_0000, 2'b11, 1, 1, 1, 1, 0, 3'd2));
    run(64'h0000_0500_0000_5000, 2, 0, 1, "R10 user fetch pxn only ok");
    build(64'h1000, 64'h0000_0600_0000_6000, 3, mk(48'h8_2000_0000, 2'b11, 1, 0, 1, 0, 0, 3'd3));
    run(64'h0000_0600_0000_6000, 2, 1, 0, "R10 priv fetch user rw");
    run(64'h0000_0600_0000_6000, 2, 0, 0, "R10 user fetch user rw ok");
    build(64'h1000, 64'h0000_0700_0000_7000, 3, mk(48'h8_3000_0000, 2'b11, 1, 1, 1, 0, 0, 3'd4));
    run(64'h0000_0700_0000_7000, 2, 1, 2, "R10 priv fetch user ro ok");
    // R2: non-canonical address
    run(64'h0001_0000_0000_0000, 0, 1, 0, "R2 address size");
    run(64'h8000_FFFF_0000_0000, 2, 0, 0, "R2 address size hi");

    @(negedge clk);
    chk({req_ready, mem_req, done}, 3'b100, "R11 idle after walks");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule